// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the 8-bit status word of a CPU whose accumulator is 16 bits wide by default. The ALU reports each finished operation to it through two strobes. A compare strobe comes with an equality result. An add/subtract strobe comes with the carry (or borrow) out of the top accumulator bit and the carry out of the bit just below it. Any other operation class raises neither strobe, and the stored flags stay as they are.

Five bits of the word are held in flip-flops: equal, carry, overflow and two general-purpose software flags. Sign and zero are not stored. They are worked out continuously from the live accumulator value, so they follow the accumulator in the same cycle it changes. Software reads the whole word through a read port. It writes through a write port that only changes the writable bits. Every flag is also available on its own output pin.

Top module: `sflag_reg`

## Requirements
- R1: A synchronous active-high reset clears every stored flag. While the accumulator is zero, the word reads 80h in the cycle after reset.
- R2: Writes to bits 7, 6, 5 and 2 of the word are ignored. Bits 4, 3, 1 and 0 load `wr_data_i` at the clock edge where `wr_en_i` is high, and read back from the next cycle.
- R3: Bit 0 (equal) loads `cmp_equal_i` at each edge where `cmp_strobe_i` is high.
- R4: Bit 1 (carry) loads `carry_top_i` at each edge where `arith_strobe_i` is high.
- R5: Bit 2 (overflow) loads `carry_top_i XOR carry_sub_i` at each edge where `arith_strobe_i` is high.
- R6: Bit 2 keeps its value at every edge without `arith_strobe_i`, including edges with a compare strobe or a software write.
- R7: Bit 6 (sign) equals the top bit of `acc_i` in the same cycle, with no register in the path.
- R8: Bit 7 (zero) is 1 in the same cycle exactly when `acc_i` is all zeros.
- R9: Bit 5 always reads 0.
- R10: When a strobe and a software write land on the same edge, the bit the strobe updates takes the hardware value. The other writable bits still take the written data.
- R11: Equal and carry hold their values at edges that carry neither their own strobe nor a write. A compare strobe does not touch carry, and an add/subtract strobe does not touch equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | ACC_W | Live value of the active accumulator |
| cmp_strobe_i | input | 1 | A compare operation finished this cycle |
| arith_strobe_i | input | 1 | An add/subtract operation finished this cycle |
| cmp_equal_i | input | 1 | Compare result: 1 means equal |
| carry_top_i | input | 1 | Carry or borrow out of the accumulator's top bit |
| carry_sub_i | input | 1 | Carry out of the bit just below the top bit |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write data |
| rd_data_o | output | 8 | Current status word |
| flag_eq_o | output | 1 | Equal flag (bit 0) |
| flag_carry_o | output | 1 | Carry flag (bit 1) |
| flag_ovf_o | output | 1 | Overflow flag (bit 2) |
| flag_sign_o | output | 1 | Sign flag (bit 6) |
| flag_zero_o | output | 1 | Zero flag (bit 7) |
| gen_flags_o | output | 2 | Software flags (bits 4:3) |

## Verification
The main vector walk drives add/subtract strobes with all four combinations of the two carry inputs. This separates the carry flag, which follows only the top carry, from overflow, which needs the two carries to differ. Compares with both results are placed between arithmetic steps, which shows that overflow and carry hold across them. Writes of all-ones, all-zeros, and a pattern limited to the protected bits show which bits accept data. Writes on the same edge as a strobe show that hardware wins only on the bit it owns. Accumulator values of zero, 8000h, 7FFFh, FFFFh and small positives tell the live sign and zero bits apart. A same-cycle change of the accumulator with no clock edge shows that these two bits are combinational.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int WORD_W  = 8;
    localparam int STORE_W = 5;

    // bit positions inside the status word
    localparam int B_EQ   = 0;
    localparam int B_CY   = 1;
    localparam int B_OV   = 2;
    localparam int B_GF0  = 3;
    localparam int B_GF1  = 4;
    localparam int B_RSV  = 5;
    localparam int B_SIGN = 6;
    localparam int B_ZERO = 7;

    // stored bits are 4:0; software may write these of them
    localparam logic [STORE_W-1:0] SW_WR_MASK = 5'b11011;
    localparam logic [STORE_W-1:0] STORE_RST  = '0;

    typedef struct packed {
        logic zero;
        logic sign;
        logic rsv;
        logic gf1;
        logic gf0;
        logic ov;
        logic cy;
        logic eq;
    } sword_t;

    typedef struct packed {
        logic cmp;
        logic arith;
        logic equal;
        logic c_top;
        logic c_sub;
    } alu_evt_t;

    typedef struct packed {
        logic [STORE_W-1:0] we;
        logic [STORE_W-1:0] val;
    } hw_upd_t;

    function automatic logic ovf_of(input logic c_top, input logic c_sub);
        return c_top ^ c_sub;
    endfunction

endpackage

// File: rtl/sflag_hw_update.sv
module sflag_hw_update
    import sflag_pkg::*;
(
    input  alu_evt_t evt_i,
    output hw_upd_t  upd_o
);

    always_comb begin
        upd_o            = '0;
        upd_o.we[B_EQ]   = evt_i.cmp;
        upd_o.val[B_EQ]  = evt_i.equal;
        upd_o.we[B_CY]   = evt_i.arith;
        upd_o.val[B_CY]  = evt_i.c_top;
        upd_o.we[B_OV]   = evt_i.arith;
        upd_o.val[B_OV]  = ovf_of(evt_i.c_top, evt_i.c_sub);
    end

endmodule

// File: rtl/sflag_live.sv
module sflag_live #(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc_i,
    output logic             sign_o,
    output logic             zero_o
);

    localparam int MSB = ACC_W - 1;

    assign sign_o = acc_i[MSB];
    assign zero_o = ~|acc_i;

endmodule

// File: rtl/sflag_store.sv
module sflag_store
    import sflag_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  hw_upd_t            upd_i,
    input  logic               wr_en_i,
    input  logic [STORE_W-1:0] wr_data_i,
    output logic [STORE_W-1:0] q_o
);

    logic [STORE_W-1:0] sw_we;
    assign sw_we = {STORE_W{wr_en_i}} & SW_WR_MASK;

    for (genvar i = 0; i < STORE_W; i++) begin : g_bit
        logic nxt;
        always_comb begin
            if (upd_i.we[i])
                nxt = upd_i.val[i];
            else if (sw_we[i])
                nxt = wr_data_i[i];
            else
                nxt = q_o[i];
        end
        always_ff @(posedge clk) begin
            if (rst) q_o[i] <= STORE_RST[i];
            else     q_o[i] <= nxt;
        end
    end

    // R1: stored flags are cleared by reset
    p_clear_r1: assert property (@(posedge clk) rst |=> (q_o == STORE_RST));

    // R2: the protected stored bit (overflow) ignores writes with no arith update
    p_ov_ro_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !upd_i.we[B_OV]) |=> $stable(q_o[B_OV]));

endmodule

// File: rtl/sflag_reg.sv
module sflag_reg
    import sflag_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             cmp_strobe_i,
    input  logic             arith_strobe_i,
    input  logic             cmp_equal_i,
    input  logic             carry_top_i,
    input  logic             carry_sub_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    output logic [7:0]       rd_data_o,
    output logic             flag_eq_o,
    output logic             flag_carry_o,
    output logic             flag_ovf_o,
    output logic             flag_sign_o,
    output logic             flag_zero_o,
    output logic [1:0]       gen_flags_o
);

    alu_evt_t           evt;
    hw_upd_t            upd;
    logic [STORE_W-1:0] stored;
    logic               live_sign;
    logic               live_zero;
    sword_t             word;
    logic               unused_wr_hi;

    assign unused_wr_hi = ^wr_data_i[WORD_W-1:STORE_W];

    assign evt = '{cmp:   cmp_strobe_i,
                   arith: arith_strobe_i,
                   equal: cmp_equal_i,
                   c_top: carry_top_i,
                   c_sub: carry_sub_i};

    sflag_hw_update u_hw (
        .evt_i (evt),
        .upd_o (upd)
    );

    sflag_live #(.ACC_W(ACC_W)) u_live (
        .acc_i  (acc_i),
        .sign_o (live_sign),
        .zero_o (live_zero)
    );

    sflag_store u_store (
        .clk       (clk),
        .rst       (rst),
        .upd_i     (upd),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i[STORE_W-1:0]),
        .q_o       (stored)
    );

    always_comb begin
        word      = '0;
        word.eq   = stored[B_EQ];
        word.cy   = stored[B_CY];
        word.ov   = stored[B_OV];
        word.gf0  = stored[B_GF0];
        word.gf1  = stored[B_GF1];
        word.rsv  = 1'b0;
        word.sign = live_sign;
        word.zero = live_zero;
    end

    assign rd_data_o    = word;
    assign flag_eq_o    = word.eq;
    assign flag_carry_o = word.cy;
    assign flag_ovf_o   = word.ov;
    assign flag_sign_o  = word.sign;
    assign flag_zero_o  = word.zero;
    assign gen_flags_o  = {word.gf1, word.gf0};

    // R3 / R10: compare result lands in equal, even against a write
    p_eq_load_r3: assert property (@(posedge clk) disable iff (rst)
        cmp_strobe_i |=> (flag_eq_o == $past(cmp_equal_i)));

    // R4: carry follows the top carry on arithmetic
    p_carry_load_r4: assert property (@(posedge clk) disable iff (rst)
        arith_strobe_i |=> (flag_carry_o == $past(carry_top_i)));

    // R5: overflow set only when the two carries differ
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (arith_strobe_i && (carry_top_i == carry_sub_i)) |=> !flag_ovf_o);

    // R6: overflow holds without an arithmetic strobe
    p_ov_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !arith_strobe_i |=> $stable(flag_ovf_o));

    // R2: software flags take written data, else hold
    p_gen_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (gen_flags_o == $past(wr_data_i[4:3])));

    // R11: carry untouched by compare-only edges
    p_carry_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!arith_strobe_i && !wr_en_i) |=> $stable(flag_carry_o));

endmodule

// File: tb/sflag_reg_bench.sv
`timescale 1ns/1ps
module sflag_reg_bench;

    localparam int ACC_W = 16;
    localparam int NVEC  = 12;
    localparam int VW    = 16 + 6 + 8 + 8;

    // {acc, cmp, arith, equal, c_top, c_sub, wr, wdata, expected word}
    localparam logic [VW-1:0] VEC [0:NVEC-1] = '{
        {16'h0000, 6'b101000, 8'h00, 8'h81},  // R3 equal set, R8 zero
        {16'h1234, 6'b010100, 8'h00, 8'h07},  // R4 R5 carry, ovf; R11 eq holds
        {16'h8000, 6'b010110, 8'h00, 8'h43},  // R5 both carries: no ovf; R7 sign
        {16'h7FFF, 6'b010010, 8'h00, 8'h05},  // R5 sub carry only: ovf
        {16'h0001, 6'b100000, 8'h00, 8'h04},  // R3 unequal, R6 ovf holds
        {16'h0001, 6'b000001, 8'hFF, 8'h1F},  // R2 write ones, R9 bit5 zero
        {16'hFFFF, 6'b000001, 8'h00, 8'h44},  // R2 write zeros, ovf kept
        {16'h0000, 6'b100001, 8'h1B, 8'h9E},  // R10 compare beats write
        {16'h0000, 6'b010101, 8'h00, 8'h86},  // R10 arith beats write
        {16'h0000, 6'b000000, 8'h00, 8'h86},  // R11 R6 idle hold
        {16'h0000, 6'b010000, 8'h00, 8'h80},  // R4 R5 clear carry and ovf
        {16'hA5A5, 6'b000001, 8'hE4, 8'h40}   // R2 protected bits ignore write
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ACC_W-1:0] acc = '0;
    logic             cmp = 1'b0, arith = 1'b0, equal = 1'b0;
    logic             c_top = 1'b0, c_sub = 1'b0, wr = 1'b0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rd;
    logic             f_eq, f_cy, f_ov, f_s, f_z;
    logic [1:0]       f_g;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sflag_reg #(.ACC_W(ACC_W)) u_sflag_reg (
        .clk (clk), .rst (rst), .acc_i (acc),
        .cmp_strobe_i (cmp), .arith_strobe_i (arith), .cmp_equal_i (equal),
        .carry_top_i (c_top), .carry_sub_i (c_sub),
        .wr_en_i (wr), .wr_data_i (wdata), .rd_data_o (rd),
        .flag_eq_o (f_eq), .flag_carry_o (f_cy), .flag_ovf_o (f_ov),
        .flag_sign_o (f_s), .flag_zero_o (f_z), .gen_flags_o (f_g)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        cmp = 0; arith = 0; equal = 0; c_top = 0; c_sub = 0; wr = 0; wdata = '0;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset word", rd, 8'h80);
        check("R1 reset flag pins", {f_z, f_s, f_g, f_ov, f_cy, f_eq}, 8'h40);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {acc, cmp, arith, equal, c_top, c_sub, wr, wdata} = VEC[i][VW-1:8];
            @(negedge clk);
            check($sformatf("vector %0d", i), rd, VEC[i][7:0]);
            idle();
        end

        // R7 R8: live flags change with no clock edge
        @(posedge clk);
        #1 acc = 16'h8001;
        #1 check("R7 sign same cycle", {6'b0, f_s, f_z}, 8'h02);
        acc = 16'h0000;
        #1 check("R8 zero same cycle", {6'b0, f_s, f_z}, 8'h01);
        acc = 16'h0100;
        #1 check("R8 nonzero word", rd, 8'h00);

        // R6: compare and write leave overflow alone
        @(negedge clk);
        arith = 1; c_top = 0; c_sub = 1;
        @(negedge clk);
        idle();
        cmp = 1; equal = 1; wr = 1; wdata = 8'h00;
        @(negedge clk);
        idle();
        check("R6 ovf after cmp+write", {7'b0, f_ov}, 8'h01);
        check("R3 R10 equal after cmp+write", {7'b0, f_eq}, 8'h01);

        // R1: mid-run reset with nonzero accumulator
        @(negedge clk);
        wr = 1; wdata = 8'h1B;
        @(negedge clk);
        idle();
        rst = 1; acc = 16'h0000;
        @(negedge clk);
        rst = 0;
        check("R1 mid-run reset", rd, 8'h80);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule